// File: doc/BRIEF.md
# Precision Time-of-Day Counter

This block keeps a free-running time of day for a packet timestamping path. The time is a 48-bit seconds count and a 30-bit nanoseconds count that rolls over at one billion. Every clock it moves forward by a nominal 8 ns, and an optional signed frequency trim turns some of those steps into 9 ns or 7 ns. Other logic reads the live time from the `curSec`/`curNs` outputs to stamp frames.

Software drives the block through a simple 16-bit word interface: a write port with address and data, and a combinational read port. The time changes only when a bit in the command word is written. A command can set an absolute time from staged words, copy the live time into a read-back snapshot so that several word reads return one coherent value, step the seconds forward or back, step the nanoseconds forward, start or stop the count, or clear everything. A backward nanosecond move is done by software as one fewer second plus a forward nanosecond step.

Top module: `ptp_tod`

## Requirements
- R1: After `rstN` is released the time is zero, the counter is stopped (`running`=0) and every readable word (addresses 0 to 15) reads 0.
- R2: Word map: 1 set-seconds[47:32], 2 set-seconds[31:16], 3 set-seconds[15:0], 4 set-ns high (bits 13:0 used), 5 set-ns[15:0], 6 step low word, 7 step high word, 8 rate high word, 9 rate low word; each of these reads back all 16 bits as written. 10/11/12 are snapshot seconds high/mid/low, 13 is snapshot ns[29:16] in bits 13:0, 14 is snapshot ns[15:0].
- R3: Address 0 is the command word and always reads 0. Its bits are one-shot: 0 clear, 1 stop, 2 start, 3 snapshot, 4 load, 5 seconds step, 6 nanoseconds step. A command written at clock edge k takes effect at edge k+1 and acts exactly once.
- R4: Load sets seconds to words 1..3 and nanoseconds to {word4[13:0], word5}; bits 15:14 of word 4 are ignored.
- R5: While running the time advances by 8 ns per clock; while stopped it holds. Start sets `running`, stop clears it, and stop wins when both are written together.
- R6: Nanoseconds stay below 1,000,000,000; an advance reaching it wraps and adds one second.
- R7: Snapshot copies the time as it was just before edge k+1 into words 10..14, which then stay unchanged while the counter keeps running.
- R8: Seconds step: magnitude is word6[3:0] (higher bits ignored); word7 bit 15 = 1 adds, 0 subtracts; the result wraps modulo 2^48 and nanoseconds are unchanged.
- R9: Nanoseconds step adds the 30-bit value {word7[13:0], word6}, wrapping at one billion with a carry of one or two seconds; it never subtracts. With both step bits set, both steps apply in the same edge.
- R10: Rate trim: magnitude {word8[13:0], word9} is added each running clock to a 30-bit fraction accumulator; on a carry that clock's advance is 9 ns if word8 bit 15 is 1, else 7 ns. Zero magnitude gives exactly 8 ns per clock. A new rate applies from the edge after its write.
- R11: When several command bits are written together, priority is clear, then load, then step, then snapshot; lower-priority time commands in the same write are dropped (start/stop are handled independently).
- R12: Clear zeroes the time, the rate words 8 and 9 and the fraction accumulator, and stops the counter unless start is written with it.
- R13: On an edge where clear, load or a step acts, no nominal advance is added.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Word write enable |
| wrAddr | input | 4 | Word write address |
| wrData | input | 16 | Word write data |
| rdAddr | input | 4 | Word read address |
| rdData | output | 16 | Word read data, combinational from `rdAddr` |
| curSec | output | 48 | Live seconds |
| curNs | output | 30 | Live nanoseconds |
| running | output | 1 | Counter is advancing |

## Verification
A command word written at edge k is held for one cycle as a registered strobe, so its effect on time, snapshot and run state is first visible after edge k+1. The bench therefore records the live time in the low phase between k and k+1 and compares it after k+1. A rate word written at edge k steers the advance from edge k+1, and reads are combinational, so the bench samples every value in the low phase of the clock. Drift is checked over whole windows of 40 clocks where the number of accumulator carries is known arithmetically.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;

  localparam int WORD_W = 16;
  localparam int ADDR_W = 4;
  localparam int SEC_W  = 48;
  localparam int NS_W   = 30;
  localparam int NS_HI_W = NS_W - WORD_W;
  localparam int unsigned NS_PER_SEC = 1_000_000_000;

  // word addresses
  localparam logic [ADDR_W-1:0] ADDR_CMD     = 4'd0;
  localparam logic [ADDR_W-1:0] ADDR_SET_SH  = 4'd1;
  localparam logic [ADDR_W-1:0] ADDR_SET_SM  = 4'd2;
  localparam logic [ADDR_W-1:0] ADDR_SET_SL  = 4'd3;
  localparam logic [ADDR_W-1:0] ADDR_SET_NH  = 4'd4;
  localparam logic [ADDR_W-1:0] ADDR_SET_NL  = 4'd5;
  localparam logic [ADDR_W-1:0] ADDR_STEP_LO = 4'd6;
  localparam logic [ADDR_W-1:0] ADDR_STEP_HI = 4'd7;
  localparam logic [ADDR_W-1:0] ADDR_RATE_HI = 4'd8;
  localparam logic [ADDR_W-1:0] ADDR_RATE_LO = 4'd9;
  localparam logic [ADDR_W-1:0] ADDR_SNAP_SH = 4'd10;
  localparam logic [ADDR_W-1:0] ADDR_SNAP_SM = 4'd11;
  localparam logic [ADDR_W-1:0] ADDR_SNAP_SL = 4'd12;
  localparam logic [ADDR_W-1:0] ADDR_SNAP_NH = 4'd13;
  localparam logic [ADDR_W-1:0] ADDR_SNAP_NL = 4'd14;

  localparam int STAGE_FIRST = 1;
  localparam int STAGE_LAST  = 9;

  // command word bit positions
  localparam int CB_CLEAR = 0;
  localparam int CB_STOP  = 1;
  localparam int CB_START = 2;
  localparam int CB_SNAP  = 3;
  localparam int CB_LOAD  = 4;
  localparam int CB_SSEC  = 5;
  localparam int CB_SNS   = 6;

  // direction flag position in high words
  localparam int DIR_BIT = 15;

  typedef struct packed {
    logic clear;
    logic load;
    logic stepSec;
    logic stepNs;
    logic snap;
    logic start;
    logic stop;
  } tod_cmd_t;

endpackage

// File: rtl/ptp_tod_ctrl.sv
module ptp_tod_ctrl
  import ptp_tod_pkg::*;
#(
  parameter int STEP_SEC_W = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [WORD_W-1:0]     wrData,
  input  logic [ADDR_W-1:0]     rdAddr,
  output logic [WORD_W-1:0]     rdData,
  input  logic [SEC_W-1:0]      snapSec,
  input  logic [NS_W-1:0]       snapNs,
  output tod_cmd_t              cmdQ,
  output logic [SEC_W-1:0]      setSec,
  output logic [NS_W-1:0]       setNs,
  output logic [STEP_SEC_W-1:0] stepSecMag,
  output logic                  stepSecAdd,
  output logic [NS_W-1:0]       stepNsMag,
  output logic [NS_W-1:0]       rateMag,
  output logic                  rateFast
);

  logic [WORD_W-1:0] stage [STAGE_FIRST:STAGE_LAST];
  logic cmdWr;
  tod_cmd_t cmdD;

  assign cmdWr = wrEn && (wrAddr == ADDR_CMD);

  // staged word registers; the rate words are also cleared by a clear strobe
  generate
    for (genvar i = STAGE_FIRST; i <= STAGE_LAST; i++) begin : g_stage
      localparam bit IS_RATE = (i == int'(ADDR_RATE_HI)) || (i == int'(ADDR_RATE_LO));
      logic [WORD_W-1:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          q <= '0;
        end else if (IS_RATE && cmdQ.clear) begin
          q <= '0;
        end else if (wrEn && (wrAddr == ADDR_W'(i))) begin
          q <= wrData;
        end
      end
      assign stage[i] = q;
    end
  endgenerate

  // command decode with priority clear > load > step > snapshot
  always_comb begin
    logic stepOk;
    logic snapOk;
    stepOk       = cmdWr && !wrData[CB_CLEAR] && !wrData[CB_LOAD];
    snapOk       = stepOk && !wrData[CB_SSEC] && !wrData[CB_SNS];
    cmdD.clear   = cmdWr && wrData[CB_CLEAR];
    cmdD.load    = cmdWr && wrData[CB_LOAD] && !wrData[CB_CLEAR];
    cmdD.stepSec = stepOk && wrData[CB_SSEC];
    cmdD.stepNs  = stepOk && wrData[CB_SNS];
    cmdD.snap    = snapOk && wrData[CB_SNAP];
    cmdD.start   = cmdWr && wrData[CB_START];
    cmdD.stop    = cmdWr && wrData[CB_STOP];
  end

  // one-cycle strobes toward the datapath
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ <= '0;
    end else begin
      cmdQ <= cmdD;
    end
  end

  // field extraction from the staged words
  assign setSec     = {stage[ADDR_SET_SH], stage[ADDR_SET_SM], stage[ADDR_SET_SL]};
  assign setNs      = {stage[ADDR_SET_NH][NS_HI_W-1:0], stage[ADDR_SET_NL]};
  assign stepSecMag = stage[ADDR_STEP_LO][STEP_SEC_W-1:0];
  assign stepSecAdd = stage[ADDR_STEP_HI][DIR_BIT];
  assign stepNsMag  = {stage[ADDR_STEP_HI][NS_HI_W-1:0], stage[ADDR_STEP_LO]};
  assign rateMag    = {stage[ADDR_RATE_HI][NS_HI_W-1:0], stage[ADDR_RATE_LO]};
  assign rateFast   = stage[ADDR_RATE_HI][DIR_BIT];

  // read mux
  always_comb begin
    rdData = '0;
    if (rdAddr >= ADDR_W'(STAGE_FIRST) && rdAddr <= ADDR_W'(STAGE_LAST)) begin
      rdData = stage[rdAddr];
    end else begin
      case (rdAddr)
        ADDR_SNAP_SH: rdData = snapSec[3*WORD_W-1:2*WORD_W];
        ADDR_SNAP_SM: rdData = snapSec[2*WORD_W-1:WORD_W];
        ADDR_SNAP_SL: rdData = snapSec[WORD_W-1:0];
        ADDR_SNAP_NH: rdData = {{(WORD_W-NS_HI_W){1'b0}}, snapNs[NS_W-1:WORD_W]};
        ADDR_SNAP_NL: rdData = snapNs[WORD_W-1:0];
        default:      rdData = '0;
      endcase
    end
  end

endmodule

// File: rtl/ptp_tod_rate.sv
module ptp_tod_rate
  import ptp_tod_pkg::*;
#(
  parameter int ACC_W   = 30,
  parameter int NOM_INC = 8,
  parameter int INC_W   = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             advance,
  input  logic [NS_W-1:0]  rateMag,
  input  logic             rateFast,
  output logic [INC_W-1:0] incNs
);

  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   accSum;
  logic             carry;

  assign accSum = {1'b0, acc} + (ACC_W+1)'(rateMag);
  assign carry  = accSum[ACC_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc <= '0;
    end else if (clr) begin
      acc <= '0;
    end else if (advance) begin
      acc <= accSum[ACC_W-1:0];
    end
  end

  always_comb begin
    if (!carry) begin
      incNs = INC_W'(NOM_INC);
    end else if (rateFast) begin
      incNs = INC_W'(NOM_INC + 1);
    end else begin
      incNs = INC_W'(NOM_INC - 1);
    end
  end

endmodule

// File: rtl/ptp_tod_dp.sv
module ptp_tod_dp
  import ptp_tod_pkg::*;
#(
  parameter int NOM_INC    = 8,
  parameter int ACC_W      = 30,
  parameter int STEP_SEC_W = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  tod_cmd_t              cmd,
  input  logic [SEC_W-1:0]      setSec,
  input  logic [NS_W-1:0]       setNs,
  input  logic [STEP_SEC_W-1:0] stepSecMag,
  input  logic                  stepSecAdd,
  input  logic [NS_W-1:0]       stepNsMag,
  input  logic [NS_W-1:0]       rateMag,
  input  logic                  rateFast,
  output logic [SEC_W-1:0]      curSec,
  output logic [NS_W-1:0]       curNs,
  output logic                  running,
  output logic [SEC_W-1:0]      snapSec,
  output logic [NS_W-1:0]       snapNs
);

  localparam int INC_W = $clog2(NOM_INC + 2) + 1;
  localparam logic [NS_W:0] ONE_SEC = (NS_W+1)'(NS_PER_SEC);
  localparam logic [NS_W:0] TWO_SEC = (NS_W+1)'(2 * NS_PER_SEC);

  logic             timeCmd;
  logic             advance;
  logic [INC_W-1:0] incNs;
  logic [NS_W-1:0]  nsAddend;
  logic [NS_W:0]    nsSum;
  logic [NS_W-1:0]  nsWrapped;
  logic [1:0]       secCarry;
  logic [SEC_W-1:0] secDelta;
  logic [SEC_W-1:0] secNext;

  assign timeCmd = cmd.clear || cmd.load || cmd.stepSec || cmd.stepNs;
  assign advance = running && !timeCmd;

  ptp_tod_rate #(
    .ACC_W  (ACC_W),
    .NOM_INC(NOM_INC),
    .INC_W  (INC_W)
  ) u_rate (
    .clk     (clk),
    .rstN    (rstN),
    .clr     (cmd.clear),
    .advance (advance),
    .rateMag (rateMag),
    .rateFast(rateFast),
    .incNs   (incNs)
  );

  // one shared adder serves both the nanosecond step and the per-clock advance
  always_comb begin
    if (cmd.stepNs) begin
      nsAddend = stepNsMag;
    end else if (advance) begin
      nsAddend = NS_W'(incNs);
    end else begin
      nsAddend = '0;
    end
    nsSum = {1'b0, curNs} + {1'b0, nsAddend};
    if (nsSum >= TWO_SEC) begin
      nsWrapped = NS_W'(nsSum - TWO_SEC);
      secCarry  = 2'd2;
    end else if (nsSum >= ONE_SEC) begin
      nsWrapped = NS_W'(nsSum - ONE_SEC);
      secCarry  = 2'd1;
    end else begin
      nsWrapped = nsSum[NS_W-1:0];
      secCarry  = 2'd0;
    end
  end

  always_comb begin
    if (!cmd.stepSec) begin
      secDelta = '0;
    end else if (stepSecAdd) begin
      secDelta = SEC_W'(stepSecMag);
    end else begin
      secDelta = SEC_W'(0) - SEC_W'(stepSecMag);
    end
    secNext = curSec + SEC_W'(secCarry) + secDelta;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curSec <= '0;
      curNs  <= '0;
    end else if (cmd.clear) begin
      curSec <= '0;
      curNs  <= '0;
    end else if (cmd.load) begin
      curSec <= setSec;
      curNs  <= setNs;
    end else if (cmd.stepSec || cmd.stepNs || advance) begin
      curSec <= secNext;
      curNs  <= nsWrapped;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
    end else if (cmd.stop) begin
      running <= 1'b0;
    end else if (cmd.start) begin
      running <= 1'b1;
    end else if (cmd.clear) begin
      running <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snapSec <= '0;
      snapNs  <= '0;
    end else if (cmd.snap) begin
      snapSec <= curSec;
      snapNs  <= curNs;
    end
  end

endmodule

// File: rtl/ptp_tod.sv
module ptp_tod
  import ptp_tod_pkg::*;
#(
  parameter int NOM_INC    = 8,
  parameter int ACC_W      = 30,
  parameter int STEP_SEC_W = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [3:0]  wrAddr,
  input  logic [15:0] wrData,
  input  logic [3:0]  rdAddr,
  output logic [15:0] rdData,
  output logic [47:0] curSec,
  output logic [29:0] curNs,
  output logic        running
);

  tod_cmd_t              cmdQ;
  logic [SEC_W-1:0]      setSec;
  logic [NS_W-1:0]       setNs;
  logic [STEP_SEC_W-1:0] stepSecMag;
  logic                  stepSecAdd;
  logic [NS_W-1:0]       stepNsMag;
  logic [NS_W-1:0]       rateMag;
  logic                  rateFast;
  logic [SEC_W-1:0]      snapSec;
  logic [NS_W-1:0]       snapNs;

  ptp_tod_ctrl #(
    .STEP_SEC_W(STEP_SEC_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .rdAddr    (rdAddr),
    .rdData    (rdData),
    .snapSec   (snapSec),
    .snapNs    (snapNs),
    .cmdQ      (cmdQ),
    .setSec    (setSec),
    .setNs     (setNs),
    .stepSecMag(stepSecMag),
    .stepSecAdd(stepSecAdd),
    .stepNsMag (stepNsMag),
    .rateMag   (rateMag),
    .rateFast  (rateFast)
  );

  ptp_tod_dp #(
    .NOM_INC   (NOM_INC),
    .ACC_W     (ACC_W),
    .STEP_SEC_W(STEP_SEC_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmdQ),
    .setSec    (setSec),
    .setNs     (setNs),
    .stepSecMag(stepSecMag),
    .stepSecAdd(stepSecAdd),
    .stepNsMag (stepNsMag),
    .rateMag   (rateMag),
    .rateFast  (rateFast),
    .curSec    (curSec),
    .curNs     (curNs),
    .running   (running),
    .snapSec   (snapSec),
    .snapNs    (snapNs)
  );

endmodule

// File: rtl/ptp_tod_chk.sv
module ptp_tod_chk
  import ptp_tod_pkg::*;
#(
  parameter int NOM_INC = 8
) (
  input logic             clk,
  input logic             rstN,
  input tod_cmd_t         cmd,
  input logic [SEC_W-1:0] setSec,
  input logic [NS_W-1:0]  setNs,
  input logic [SEC_W-1:0] curSec,
  input logic [NS_W-1:0]  curNs,
  input logic             running,
  input logic [SEC_W-1:0] snapSec,
  input logic [NS_W-1:0]  snapNs
);

  logic timeCmd;
  assign timeCmd = cmd.clear || cmd.load || cmd.stepSec || cmd.stepNs;

  // R6
  ns_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    curNs < NS_W'(NS_PER_SEC));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !timeCmd) |=> ($stable(curSec) && $stable(curNs)));

  // R5
  step_size_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && !timeCmd && curNs < NS_W'(NS_PER_SEC - 16)) |=>
      (curNs >= $past(curNs) + NS_W'(NOM_INC - 1) &&
       curNs <= $past(curNs) + NS_W'(NOM_INC + 1)));

  // R4
  load_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load |=> (curSec == $past(setSec) && curNs == $past(setNs)));

  // R12
  clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clear |=> (curSec == '0 && curNs == '0));

  // R7
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.snap |=> ($stable(snapSec) && $stable(snapNs)));

endmodule

bind ptp_tod ptp_tod_chk #(.NOM_INC(NOM_INC)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .cmd    (cmdQ),
  .setSec (setSec),
  .setNs  (setNs),
  .curSec (curSec),
  .curNs  (curNs),
  .running(running),
  .snapSec(snapSec),
  .snapNs (snapNs)
);

// File: tb/sim_ptp_tod.sv
module sim_ptp_tod;

  localparam int CLK_PERIOD = 10;
  localparam longint NSPS = 1000000000;

  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [3:0]  wrAddr;
  logic [15:0] wrData;
  logic [3:0]  rdAddr;
  logic [15:0] rdData;
  logic [47:0] curSec;
  logic [29:0] curNs;
  logic        running;

  int vecs = 0;
  int errs = 0;

  logic [47:0] preSec;
  logic [29:0] preNs;
  logic [47:0] s0;
  logic [29:0] n0;
  logic [15:0] w;
  logic [47:0] snapS;
  logic [29:0] snapN;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptp_tod u0 (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rdAddr (rdAddr),
    .rdData (rdData),
    .curSec (curSec),
    .curNs  (curNs),
    .running(running)
  );

  task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // command write; records the time seen just before the acting edge
  task automatic doCmd(input logic [15:0] bits);
    wr(4'd0, bits);
    preSec = curSec;
    preNs  = curNs;
    @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic readSnap(output logic [47:0] s, output logic [29:0] n);
    logic [15:0] a, b, c;
    rd(4'd10, a); rd(4'd11, b); rd(4'd12, c);
    s = {a, b, c};
    rd(4'd13, a); rd(4'd14, b);
    n = {a[13:0], b};
  endtask

  function automatic longint deltaNs(input logic [47:0] sa, input logic [29:0] na,
                                     input logic [47:0] sb, input logic [29:0] nb);
    return (longint'(sb) - longint'(sa)) * NSPS + (longint'(nb) - longint'(na));
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    errs++;
    vecs++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    longint unsigned sum;
    logic [47:0] eSec;
    rstN = 1'b0; wrEn = 1'b0; wrAddr = '0; wrData = '0; rdAddr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 sec", 64'(curSec), 64'd0);
    chk("R1 ns", 64'(curNs), 64'd0);
    chk("R1 running", 64'(running), 64'd0);
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), w);
      chk("R1 word", 64'(w), 64'd0);
    end

    // R2 staged words read back as written
    wr(4'd1, 16'h0001); wr(4'd2, 16'h0002); wr(4'd3, 16'h0003);
    wr(4'd4, 16'hFB9A); wr(4'd5, 16'hC9F6);
    rd(4'd1, w); chk("R2 word1", 64'(w), 64'h0001);
    rd(4'd3, w); chk("R2 word3", 64'(w), 64'h0003);
    rd(4'd4, w); chk("R2 word4", 64'(w), 64'hFB9A);
    rd(4'd5, w); chk("R2 word5", 64'(w), 64'hC9F6);

    // R4 load while stopped, upper bits of word 4 ignored
    doCmd(16'h0010);
    chk("R4 load sec", 64'(curSec), 64'h0001_0002_0003);
    chk("R4 load ns", 64'(curNs), 64'd999999990);
    rd(4'd0, w); chk("R3 cmd reads zero", 64'(w), 64'd0);

    // R5 holds while stopped; R3 load did not repeat
    repeat (6) @(negedge clk);
    chk("R5 hold ns", 64'(curNs), 64'd999999990);

    // R5 start and stop together: stop wins
    doCmd(16'h0006);
    chk("R5 stop wins", 64'(running), 64'd0);

    doCmd(16'h0004);
    chk("R5 running", 64'(running), 64'd1);
    chk("R5 not yet advanced", 64'(curNs), 64'd999999990);
    @(negedge clk);
    chk("R5 +8", 64'(curNs), 64'd999999998);
    @(negedge clk);
    chk("R6 wrap ns", 64'(curNs), 64'd6);
    chk("R6 wrap sec", 64'(curSec), 64'h0001_0002_0004);

    // R5 sweep of nominal advance
    s0 = curSec; n0 = curNs;
    for (int n = 1; n <= 24; n++) begin
      @(negedge clk);
      chk("R5 sweep", 64'(deltaNs(s0, n0, curSec, curNs)), 64'(8 * n));
    end

    // R7 snapshot coherent while counter keeps running
    doCmd(16'h0008);
    repeat (5) @(negedge clk);
    readSnap(snapS, snapN);
    chk("R7 snap sec", 64'(snapS), 64'(preSec));
    chk("R7 snap ns", 64'(snapN), 64'(preNs));
    chk("R7 live moved", 64'(deltaNs(preSec, preNs, curSec, curNs)), 64'd48);

    // R11 load beats step and snapshot; R13 no advance on load edge
    doCmd(16'h0078);
    chk("R11 load wins sec", 64'(curSec), 64'h0001_0002_0003);
    chk("R11 load wins ns", 64'(curNs), 64'd999999990);
    readSnap(s0, n0);
    chk("R11 snap dropped sec", 64'(s0), 64'(snapS));
    chk("R11 snap dropped ns", 64'(n0), 64'(snapN));

    // R8 seconds step sweep, both directions, upper low-word bits ignored
    for (int m = 0; m < 16; m++) begin
      for (int d = 0; d < 2; d++) begin
        wr(4'd6, 16'h0A50 | 16'(m));
        wr(4'd7, (d == 1) ? 16'h8000 : 16'h0000);
        doCmd(16'h0020);
        eSec = (d == 1) ? preSec + 48'(m) : preSec - 48'(m);
        chk("R8 step sec", 64'(curSec), 64'(eSec));
        chk("R13 step ns kept", 64'(curNs), 64'(preNs));
      end
    end

    // R9 nanosecond step sweep
    for (int k = 0; k < 6; k++) begin
      logic [29:0] mag;
      case (k)
        0: mag = 30'd1;
        1: mag = 30'd8;
        2: mag = 30'd999999995;
        3: mag = 30'h3FFFFFFF;
        4: mag = 30'd500000000;
        default: mag = 30'd0;
      endcase
      wr(4'd6, mag[15:0]);
      wr(4'd7, {2'b00, mag[29:16]});
      doCmd(16'h0040);
      sum = 64'(preNs) + 64'(mag);
      chk("R9 step ns", 64'(curNs), sum % 64'(NSPS));
      chk("R9 step carry", 64'(curSec), 64'(preSec) + sum / 64'(NSPS));
    end

    // R9 both steps in one command: +5 s and +5 ns
    wr(4'd6, 16'h0005);
    wr(4'd7, 16'h8000);
    doCmd(16'h0060);
    sum = 64'(preNs) + 64'd5;
    chk("R9 dual ns", 64'(curNs), sum % 64'(NSPS));
    chk("R9 dual sec", 64'(curSec), 64'(preSec) + 64'd5 + sum / 64'(NSPS));

    // R10 rate trim faster, slower, then nominal
    wr(4'd9, 16'h0000);
    wr(4'd8, 16'h9000);
    s0 = curSec; n0 = curNs;
    repeat (40) @(negedge clk);
    chk("R10 faster", 64'(deltaNs(s0, n0, curSec, curNs)), 64'd330);
    wr(4'd8, 16'h1000);
    s0 = curSec; n0 = curNs;
    repeat (40) @(negedge clk);
    chk("R10 slower", 64'(deltaNs(s0, n0, curSec, curNs)), 64'd310);
    wr(4'd8, 16'h0000);
    s0 = curSec; n0 = curNs;
    repeat (16) @(negedge clk);
    chk("R10 nominal", 64'(deltaNs(s0, n0, curSec, curNs)), 64'd128);

    // R3 one-shot strobe: step while stopped acts once
    doCmd(16'h0002);
    chk("R5 stopped", 64'(running), 64'd0);
    wr(4'd6, 16'h0001);
    wr(4'd7, 16'h8000);
    doCmd(16'h0020);
    chk("R3 single step", 64'(curSec), 64'(preSec) + 64'd1);
    s0 = curSec; n0 = curNs;
    repeat (5) @(negedge clk);
    chk("R3 no repeat sec", 64'(curSec), 64'(s0));
    chk("R3 no repeat ns", 64'(curNs), 64'(n0));

    // R12 clear beats load, stops, clears rate words
    wr(4'd8, 16'h9234);
    wr(4'd9, 16'h5678);
    doCmd(16'h0004);
    doCmd(16'h0011);
    chk("R12 sec", 64'(curSec), 64'd0);
    chk("R12 ns", 64'(curNs), 64'd0);
    chk("R12 stopped", 64'(running), 64'd0);
    rd(4'd8, w); chk("R12 rate hi", 64'(w), 64'd0);
    rd(4'd9, w); chk("R12 rate lo", 64'(w), 64'd0);
    repeat (4) @(negedge clk);
    chk("R12 held", 64'(curNs), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule